// File: doc/BRIEF.md
# Byte-Select SRAM Bus Controller

This block connects a simple host request port to an asynchronous 16-bit SRAM that has separate active-low upper-byte and lower-byte select pins. The host presents an address, write data, a two-bit byte-enable and a write flag. The block then runs one bus cycle: a setup cycle, a strobe phase that software can stretch with a wait count and, for some writes, a hold phase. When the cycle is done it returns a one-cycle acknowledge, along with read data and a per-byte valid mask.

A mode input selects one of two write timing schemes. In mode 0 the direction line goes low for the whole write, and the byte selects pulse during the strobe phase as the actual write strobes. In mode 1 the byte selects stay asserted for the whole access, the direction line pulses low only during the strobe phase as the write strobe, and a 2-bit hold count keeps address and data on the bus for extra cycles after that strobe ends. In both modes a read drives the byte selects for the enabled bytes. Mode, wait count and hold count are captured when a request is accepted.

Top module: `bsram_ctrl`

## Requirements
- R1: A request with byte-enable 00 is acknowledged in the cycle after acceptance. No bus cycle occurs: cs_no, rd_no, rw_o and bs_no stay high, data_oe_o stays low, and rdata_o and rvalid_o read zero at the acknowledge.
- R2: A request with a non-zero byte-enable gives one setup cycle and then wait+1 strobe cycles, both with cs_no low. Any hold cycles follow. ack_o is high for exactly one cycle, the cycle after the last bus cycle, and cs_no is high again in that cycle.
- R3: For a read, rd_no is low in exactly the wait+1 strobe cycles and rw_o stays high. In mode 0, bs_no[b] is low in exactly those strobe cycles for each enabled byte b.
- R4: For a mode-0 write, rw_o is low from the setup cycle through the strobe phase (wait+2 cycles), bs_no[b] is low only in the strobe cycles for enabled bytes, and no hold cycles occur whatever the hold setting.
- R5: In mode 1, bs_no[b] is low for an enabled byte in every cycle cs_no is low, for reads and for writes.
- R6: For a mode-1 write, rw_o is low only in the strobe cycles. Exactly hold cycles (0 to 3) follow with cs_no low and rw_o high.
- R7: During a write, data_o equals the write data and data_oe_o is high from the first strobe cycle to the end of the hold phase. At all other times data_oe_o is low and data_o is zero. addr_o equals the request address while cs_no is low.
- R8: Read data is sampled from data_i in the last strobe cycle. At the acknowledge, rdata_o carries the sampled byte for each enabled byte and zero for each disabled byte, and rvalid_o equals the byte-enable. Bit 1 selects data[15:8] and bs_no[1]; bit 0 selects data[7:0] and bs_no[0]. After a write, rvalid_o is 0 and rdata_o is 0.
- R9: mode_i, wait_i and hold_i are captured at acceptance. Changing them during an access has no effect on that access.
- R10: After reset, cs_no, rd_no, rw_o and bs_no are high, and data_oe_o and ack_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: byte selects strobe the write; 1: direction line strobes the write |
| wait_i | input | WAIT_W | Extra strobe cycles |
| hold_i | input | 2 | Hold cycles after a mode-1 write strobe |
| req_i | input | 1 | Request, accepted when the block is idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables (bit 1 upper byte) |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, disabled bytes zero |
| rvalid_o | output | 2 | Valid mask of read bytes at ack |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| rw_o | output | 1 | Direction: 1 read/idle, 0 write |
| bs_no | output | 2 | Byte selects, active low |
| addr_o | output | AW | Memory address |
| data_o | output | 16 | Bus write data |
| data_oe_o | output | 1 | Bus drive enable; low = released |
| data_i | input | 16 | Bus read data |

## Verification
Numbering the cycles after the accepting edge from 1, the setup cycle is cycle 1, the strobe phase covers cycles 2 to wait+2, any hold cycles follow, and the acknowledge falls in cycle wait+3+hold (cycle 1 when the byte-enable is 00). The bench samples every output at the falling edge of each of these cycles and counts how many cycles each strobe is active. It changes data_i on every cycle, so a read that samples in the wrong cycle returns a wrong value. It also scrambles the configuration inputs right after acceptance, so any access that reads them late shows wrong counts.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int DATA_W = 16;
  localparam int NBYTE  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } st_e;
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              skip_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [1:0]        hold_i,
  input  logic              hold_en_i,
  output st_e               state_o,
  output logic              last_o
);
  localparam int CNT_W = (WAIT_W > 2) ? WAIT_W : 2;

  st_e              state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_q <= skip_i ? ST_DONE : ST_SETUP;
        ST_SETUP: begin
          state_q <= ST_STROBE;
          cnt_q   <= CNT_W'(wait_i);
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            if (hold_en_i && hold_i != 2'd0) begin
              state_q <= ST_HOLD;
              cnt_q   <= CNT_W'(hold_i - 2'd1);
            end else begin
              state_q <= ST_DONE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign last_o  = (cnt_q == '0);

  // R2
  strobe_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |=> (state_q == ST_STROBE));

  // R6
  hold_only_mode1_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> hold_en_i);
endmodule

// File: rtl/bsram_drv.sv
module bsram_drv
  import bsram_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               state_i,
  input  logic              mode_i,
  input  logic              we_i,
  input  logic [NBYTE-1:0]  be_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cs_no,
  output logic              rd_no,
  output logic              rw_o,
  output logic [NBYTE-1:0]  bs_no,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_o
);
  logic busy, strobe, bs_act;

  assign busy   = (state_i == ST_SETUP) || (state_i == ST_STROBE) || (state_i == ST_HOLD);
  assign strobe = (state_i == ST_STROBE);
  // mode 1 frames the whole access; mode 0 pulses only in the strobe phase
  assign bs_act = mode_i ? busy : strobe;

  assign cs_no     = !busy;
  assign rd_no     = !(strobe && !we_i);
  assign rw_o      = !(we_i && (strobe || (state_i == ST_SETUP && !mode_i)));
  assign bs_no     = ~(be_i & {NBYTE{bs_act}});
  assign data_oe_o = we_i && (strobe || state_i == ST_HOLD);
  assign data_o    = data_oe_o ? wdata_i : '0;
  assign addr_o    = busy ? addr_i : '0;
  assign ack_o     = (state_i == ST_DONE);

  // R7
  drive_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !cs_no);

  // R7
  no_drive_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !data_oe_o);

  // R5
  bs_steady_mode1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && mode_i && $past(!cs_no)) |-> $stable(bs_no));
endmodule

// File: rtl/bsram_rcap.sv
module bsram_rcap
  import bsram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              done_i,
  input  logic              we_i,
  input  logic [NBYTE-1:0]  be_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NBYTE-1:0]  rvalid_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       byte_q <= '0;
      else if (clear_i)  byte_q <= '0;
      else if (sample_i) byte_q <= be_i[b] ? data_i[b*8 +: 8] : 8'h00;
    end
    assign rdata_o[b*8 +: 8] = byte_q;
  end

  assign rvalid_o = (done_i && !we_i) ? be_i : '0;

  // R8
  rvalid_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o != '0) |-> done_i);
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW     = 20,
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [1:0]        hold_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        be_i,
  output logic              ack_o,
  output logic [15:0]       rdata_o,
  output logic [1:0]        rvalid_o,
  output logic              cs_no,
  output logic              rd_no,
  output logic              rw_o,
  output logic [1:0]        bs_no,
  output logic [AW-1:0]     addr_o,
  output logic [15:0]       data_o,
  output logic              data_oe_o,
  input  logic [15:0]       data_i
);
  st_e               state;
  logic              last, accept;
  logic              mode_q, we_q;
  logic [WAIT_W-1:0] wait_q;
  logic [1:0]        hold_q;
  logic [NBYTE-1:0]  be_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept = req_i && (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      we_q    <= 1'b0;
      wait_q  <= '0;
      hold_q  <= '0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mode_q  <= mode_i;
      we_q    <= we_i;
      wait_q  <= wait_i;
      hold_q  <= hold_i;
      be_q    <= be_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  bsram_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .skip_i    (be_i == 2'b00),
    .wait_i    (wait_q),
    .hold_i    (hold_q),
    .hold_en_i (mode_q && we_q),
    .state_o   (state),
    .last_o    (last)
  );

  bsram_drv #(.AW(AW)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .mode_i    (mode_q),
    .we_i      (we_q),
    .be_i      (be_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .cs_no     (cs_no),
    .rd_no     (rd_no),
    .rw_o      (rw_o),
    .bs_no     (bs_no),
    .addr_o    (addr_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .ack_o     (ack_o)
  );

  bsram_rcap u_rcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .sample_i ((state == ST_STROBE) && last && !we_q),
    .done_i   (state == ST_DONE),
    .we_i     (we_q),
    .be_i     (be_q),
    .data_i   (data_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // R1
  skip_no_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && be_i == 2'b00) |=> (cs_no && ack_o));

  // R2
  start_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && be_i != 2'b00) |=> !cs_no);

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: tb/sim_bsram_ctrl.sv
`timescale 1ns/1ps
module sim_bsram_ctrl;
  localparam int AW = 12;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode, req, we;
  logic [WW-1:0] wait_c;
  logic [1:0]    hold_c, be;
  logic [AW-1:0] addr;
  logic [15:0]   wdata, din;
  logic          ack, cs_n, rd_n, rw, oe;
  logic [15:0]   rdata, dout;
  logic [1:0]    rvalid, bs_n;
  logic [AW-1:0] aout;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bsram_ctrl #(.AW(AW), .WAIT_W(WW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wait_i(wait_c), .hold_i(hold_c),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .ack_o(ack), .rdata_o(rdata), .rvalid_o(rvalid), .cs_no(cs_n), .rd_no(rd_n),
    .rw_o(rw), .bs_no(bs_n), .addr_o(aout), .data_o(dout), .data_oe_o(oe), .data_i(din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int n, input int t);
    return {8'(t) ^ 8'h5A, 8'(n * 37 + t)};
  endfunction

  task automatic run(input bit m, input bit w, input logic [1:0] b, input int wt, input int h, input int t);
    int n, n_ack, n_cs, n_rd, n_rwl, n_oe, mism;
    int n_bs [2];
    int hh, e_ack;
    logic [15:0] rd_got, rd_exp;
    logic [1:0]  rv_got;
    n_cs = 0; n_rd = 0; n_rwl = 0; n_oe = 0; mism = 0; n_ack = 0;
    n_bs[0] = 0; n_bs[1] = 0; rd_got = '0; rv_got = '0;
    mode = m; we = w; be = b; wait_c = WW'(wt); hold_c = 2'(h);
    addr = AW'(t * 29 + 5); wdata = 16'(t * 1234 + 77); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    // R9: scramble configuration during the access
    mode = ~m; wait_c = ~WW'(wt); hold_c = ~2'(h);
    n = 1;
    while (n < 40) begin
      if (!cs_n) begin
        n_cs++;
        if (aout != addr) mism++;
      end
      if (!rd_n) n_rd++;
      if (!rw) n_rwl++;
      if (!bs_n[0]) n_bs[0]++;
      if (!bs_n[1]) n_bs[1]++;
      if (oe) begin
        n_oe++;
        if (dout != wdata) mism++;
      end else if (dout != 16'h0) mism++;
      if (ack) begin
        n_ack = n; rd_got = rdata; rv_got = rvalid;
        break;
      end
      din = pat(n, t);
      n++;
      @(negedge clk);
    end
    hh = (m && w) ? h : 0;
    e_ack = (b == 2'b00) ? 1 : wt + 3 + hh;
    chk(n_ack == e_ack, "R2 ack cycle", n_ack, e_ack);
    if (b == 2'b00) begin
      chk(n_cs + n_rd + n_rwl + n_oe + n_bs[0] + n_bs[1] == 0, "R1 bus idle", n_cs + n_rd + n_rwl + n_oe, 0);
      chk(rd_got == 16'h0 && rv_got == 2'b00, "R1 rdata/rvalid", int'(rd_got), 0);
    end else begin
      chk(n_cs == wt + 2 + hh, "R2 cs cycles", n_cs, wt + 2 + hh);
      chk(n_rd == (w ? 0 : wt + 1), "R3 rd cycles", n_rd, w ? 0 : wt + 1);
      if (w) chk(n_rwl == (m ? wt + 1 : wt + 2), m ? "R6 rw low cycles" : "R4 rw low cycles", n_rwl, m ? wt + 1 : wt + 2);
      else   chk(n_rwl == 0, "R3 rw high on read", n_rwl, 0);
      for (int k = 0; k < 2; k++) begin
        int e;
        e = b[k] ? (m ? wt + 2 + hh : wt + 1) : 0;
        chk(n_bs[k] == e, m ? "R5 bs cycles" : (w ? "R4 bs cycles" : "R3 bs cycles"), n_bs[k], e);
      end
      chk(n_oe == (w ? wt + 1 + hh : 0), "R7 oe cycles", n_oe, w ? wt + 1 + hh : 0);
      chk(mism == 0, "R7 addr/data mismatches", mism, 0);
      rd_exp = w ? 16'h0 : (pat(wt + 2, t) & {{8{b[1]}}, {8{b[0]}}});
      chk(rd_got == rd_exp, "R8 rdata", int'(rd_got), int'(rd_exp));
      chk(rv_got == (w ? 2'b00 : b), "R8 rvalid", int'(rv_got), w ? 0 : int'(b));
    end
    @(negedge clk);
    chk(!ack && cs_n, "R2 ack single cycle", int'(ack), 0);
  endtask

  initial begin
    int t;
    mode = 0; req = 0; we = 0; wait_c = '0; hold_c = '0; be = '0;
    addr = '0; wdata = '0; din = '0;
    repeat (3) @(negedge clk);
    chk(cs_n && rd_n && rw && bs_n == 2'b11 && !oe && !ack, "R10 reset outputs",
        int'({cs_n, rd_n, rw, bs_n, oe, ack}), 'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && rd_n && rw && bs_n == 2'b11 && !oe && !ack, "R10 idle after reset",
        int'({cs_n, rd_n, rw, bs_n, oe, ack}), 'b1111100);
    t = 0;
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int b = 0; b < 4; b++)
          for (int wt = 0; wt < 4; wt++)
            for (int h = 0; h < 4; h++) begin
              run(m[0], w[0], 2'(b), wt, h, t);
              t++;
            end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule